// File: doc/BRIEF.md
# Registered Barrel Shifter with Normalise Count Output

This block is a 16-bit shifter datapath. At each rising clock edge it captures a data word, a 4-bit operation code and a 4-bit shift amount. In the cycle that follows it presents the result: a logical or arithmetic shift, a rotate, a normalise, or a field extract. It runs on its own, separate from any arithmetic unit, and accepts a new operation every cycle.

The shift amount normally comes in on a shift-amount port. During a normalise the block works out the amount itself: the number of left shifts that bring the first bit differing from the sign into the bit just below the sign. It applies that shift and offers the count on an output with an enable, ready for a bidirectional pad. A strap input can hold that enable low so the pad stays an input.

The block keeps the previous cycle's data word in a second register. To extract any 16-bit field from a 32-bit value, present the upper half in one cycle and the lower half with the extract code in the next cycle.

Top module: `bsh_top`

## Requirements
- R1: While rst_ni is low, and after its release until the first operation is captured, data_o is 0 and amt_oe_o is 0.
- R2: op_i, amt_i and data_i are captured on a rising edge, and the result appears on data_o after that edge, stable until the next one. Code 0 and every code from 7 to 15 pass the captured word through unchanged.
- R3: Code 1 shifts left and code 2 shifts right by the captured amount. In both cases the vacated bits are 0.
- R4: Code 3 shifts right by the captured amount and fills the vacated bits with bit 15 of the word.
- R5: Code 4 rotates left by the captured amount. Bit i moves to bit (i+amount) mod 16.
- R6: Code 5 (normalise) finds the highest bit index i in 14..0 whose bit differs from bit 15, and sets count = 14 - i, or 15 if no bit differs. data_o is the word shifted left by count with zero fill, and amt_o is count.
- R7: During code 5 the captured amt_i has no effect on data_o or amt_o.
- R8: amt_oe_o is 1 exactly when the captured code is 5 and sv_lock_i is low. sv_lock_i high holds amt_oe_o at 0 but does not change the normalise result.
- R9: Code 6 outputs bits [amount+15 : amount] of the 32-bit value {word captured one edge earlier, word captured now}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Data word to shift |
| op_i | input | 4 | Operation code |
| amt_i | input | 4 | Inbound half of the shift-amount pad |
| sv_lock_i | input | 1 | Strap: high keeps the shift-amount pad input only |
| data_o | output | 16 | Shift result |
| amt_o | output | 4 | Outbound half of the shift-amount pad: normalise count |
| amt_oe_o | output | 1 | Drive enable for the shift-amount pad |

## Verification
The bench goes after the amount extremes 0 and 15 for every shift kind. A design that shifts by 16-amount, or gets the rotate wrap wrong, returns a corrupted word there. It normalises 0, all-ones and words whose first differing bit sits right below the sign. A count that does not saturate at 15, or that is off by one, shows up as a wrong shift and a wrong amt_o. It puts a garbage amount on amt_i during a normalise and toggles the lock strap, which catches a mux that reads the pad or an enable that ignores the strap. Extracts at amounts 0, 4 and 15 catch swapped halves or a missing one-cycle hold of the upper word.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 4'd0,
    OP_LSL  = 4'd1,
    OP_LSR  = 4'd2,
    OP_ASR  = 4'd3,
    OP_ROL  = 4'd4,
    OP_NORM = 4'd5,
    OP_XTR  = 4'd6
  } bsh_op_e;
endpackage

// File: rtl/bsh_norm_count.sv
module bsh_norm_count #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  output logic [AW-1:0] cnt_o
);
  // highest differing bit wins: later loop iterations overwrite
  always_comb begin
    cnt_o = AW'(W - 1);
    for (int i = 0; i < W - 1; i++) begin
      if (x_i[i] != x_i[W-1]) cnt_o = AW'(W - 2 - i);
    end
  end
endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core
  import bsh_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [AW-1:0]   amt_i,
  input  logic [W-1:0]    lo_i,
  input  logic [W-1:0]    hi_i,
  output logic [W-1:0]    res_o
);
  logic [2*W-1:0] rot_w;
  logic [2*W-1:0] xtr_w;

  assign rot_w = {lo_i, lo_i} << amt_i;
  assign xtr_w = {hi_i, lo_i} >> amt_i;

  always_comb begin
    case (op_i)
      OP_LSL, OP_NORM: res_o = lo_i << amt_i;
      OP_LSR:          res_o = lo_i >> amt_i;
      OP_ASR:          res_o = W'($signed(lo_i) >>> amt_i);
      OP_ROL:          res_o = rot_w[2*W-1:W];
      OP_XTR:          res_o = xtr_w[W-1:0];
      default:         res_o = lo_i;
    endcase
  end
endmodule

// File: rtl/bsh_top.sv
module bsh_top
  import bsh_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    data_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [AW-1:0]   amt_i,
  input  logic            sv_lock_i,
  output logic [W-1:0]    data_o,
  output logic [AW-1:0]   amt_o,
  output logic            amt_oe_o
);
  logic [OP_W-1:0] op_q;
  logic [AW-1:0]   amt_q;
  logic [W-1:0]    lo_q;
  logic [W-1:0]    hi_q;
  logic [AW-1:0]   norm_cnt;
  logic [AW-1:0]   eff_amt;
  logic            is_norm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_PASS;
      amt_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      op_q  <= op_i;
      amt_q <= amt_i;
      lo_q  <= data_i;
      hi_q  <= lo_q;  // upper half for two-cycle extract
    end
  end

  bsh_norm_count #(.W(W), .AW(AW)) u_norm (
    .x_i  (lo_q),
    .cnt_o(norm_cnt)
  );

  assign is_norm = (op_q == OP_NORM);
  // pad value never feeds back while normalising
  assign eff_amt = is_norm ? norm_cnt : amt_q;

  bsh_shift_core #(.W(W), .AW(AW)) u_core (
    .op_i (op_q),
    .amt_i(eff_amt),
    .lo_i (lo_q),
    .hi_i (hi_q),
    .res_o(data_o)
  );

  assign amt_o    = norm_cnt;
  assign amt_oe_o = is_norm & ~sv_lock_i;

  // R8
  a_r8_lock_holds_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sv_lock_i |-> !amt_oe_o);
  // R8
  a_r8_drive_only_norm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amt_oe_o |-> $past(op_i) == OP_NORM);
  // R6
  a_r6_norm_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_norm && amt_o != AW'(W - 1)) |-> data_o[W-1] != data_o[W-2]);
  // R4
  a_r4_asr_keeps_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_ASR) |-> data_o[W-1] == $past(data_i[W-1]));
  // R5
  a_r5_rol_keeps_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_ROL) |-> $countones(data_o) == $countones($past(data_i)));
  // R3
  a_r3_lsl_zero_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_LSL && amt_q != '0) |-> !data_o[0]);
endmodule

// File: tb/bsh_top_tb.sv
module bsh_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data_i = '0;
  logic [3:0]  op_i = '0;
  logic [3:0]  amt_i = '0;
  logic        lock_i = 1'b0;
  logic [15:0] data_o;
  logic [3:0]  amt_o;
  logic        amt_oe_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] d;
    logic        oe;
    logic        chk_amt;
    logic [3:0]  amt;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        mon_it;
  logic [15:0] prev_w = '0;

  always #4 clk = ~clk;

  bsh_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .op_i(op_i), .amt_i(amt_i),
    .sv_lock_i(lock_i), .data_o(data_o), .amt_o(amt_o), .amt_oe_o(amt_oe_o)
  );

  function automatic logic [3:0] ref_cnt(input logic [15:0] x);
    for (int i = 14; i >= 0; i--) if (x[i] != x[15]) return 4'(14 - i);
    return 4'd15;
  endfunction

  function automatic logic [15:0] ref_res(input logic [3:0] op, input logic [3:0] a,
                                          input logic [15:0] x, input logic [15:0] up);
    logic [15:0] r;
    logic [31:0] cat;
    logic [3:0]  c;
    r = '0;
    cat = {up, x};
    case (op)
      4'd1: for (int i = 0; i < 16; i++) if (i >= a) r[i] = x[i - a];
      4'd2: for (int i = 0; i < 16; i++) if (i + a < 16) r[i] = x[i + a];
      4'd3: for (int i = 0; i < 16; i++) r[i] = (i + a < 16) ? x[i + a] : x[15];
      4'd4: for (int i = 0; i < 16; i++) r[(i + a) % 16] = x[i];
      4'd5: begin
        c = ref_cnt(x);
        for (int i = 0; i < 16; i++) if (i >= c) r[i] = x[i - c];
      end
      4'd6: for (int i = 0; i < 16; i++) r[i] = cat[i + a];
      default: r = x;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] op, input logic [3:0] a,
                      input logic [15:0] x, input logic lk);
    exp_t e;
    @(negedge clk);
    op_i = op; amt_i = a; data_i = x; lock_i = lk;
    e.d       = ref_res(op, a, x, prev_w);
    e.oe      = (op == 4'd5) && !lk;
    e.chk_amt = (op == 4'd5);
    e.amt     = ref_cnt(x);
    e.tag     = tag;
    sb_q.push_back(e);
    prev_w = x;
  endtask

  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      mon_it = sb_q.pop_front();
      check(mon_it.tag, "data_o", data_o, mon_it.d);
      check(mon_it.tag, "amt_oe_o", {15'd0, amt_oe_o}, {15'd0, mon_it.oe});
      if (mon_it.chk_amt) check(mon_it.tag, "amt_o", {12'd0, amt_o}, {12'd0, mon_it.amt});
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    data_i = 16'hBEEF; op_i = 4'd5; amt_i = 4'd7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset data_o", data_o, 16'h0000);
    check("R1", "reset amt_oe_o", {15'd0, amt_oe_o}, 16'h0000);
    rst_n = 1'b1;
    #1;
    check("R1", "post-release data_o", data_o, 16'h0000);

    step("R2", 4'd0, 4'd3, 16'h1234, 1'b0);
    step("R2", 4'd9, 4'd5, 16'hA5C3, 1'b0);
    step("R2", 4'd15, 4'd1, 16'h0F0F, 1'b0);
    step("R3", 4'd1, 4'd3, 16'h8001, 1'b0);
    step("R3", 4'd1, 4'd0, 16'hC3A5, 1'b0);
    step("R3", 4'd1, 4'd15, 16'hFFFF, 1'b0);
    step("R3", 4'd2, 4'd4, 16'hF0F0, 1'b0);
    step("R3", 4'd2, 4'd15, 16'h8000, 1'b0);
    step("R4", 4'd3, 4'd4, 16'h8000, 1'b0);
    step("R4", 4'd3, 4'd15, 16'h7FFF, 1'b0);
    step("R4", 4'd3, 4'd15, 16'h9234, 1'b0);
    step("R4", 4'd3, 4'd0, 16'h9234, 1'b0);
    step("R5", 4'd4, 4'd1, 16'h8001, 1'b0);
    step("R5", 4'd4, 4'd15, 16'h0003, 1'b0);
    step("R5", 4'd4, 4'd8, 16'h12F4, 1'b0);
    step("R6", 4'd5, 4'd0, 16'h0001, 1'b0);
    step("R6", 4'd5, 4'd0, 16'h0000, 1'b0);
    step("R6", 4'd5, 4'd0, 16'hFFFF, 1'b0);
    step("R6", 4'd5, 4'd0, 16'hC000, 1'b0);
    step("R6", 4'd5, 4'd0, 16'hFFFE, 1'b0);
    step("R7", 4'd5, 4'd15, 16'h4000, 1'b0);
    step("R7", 4'd5, 4'd9, 16'h0123, 1'b0);
    step("R8", 4'd5, 4'd6, 16'h0040, 1'b1);
    step("R8", 4'd1, 4'd2, 16'h0040, 1'b0);
    step("R8", 4'd5, 4'd0, 16'hF800, 1'b0);
    step("R9", 4'd0, 4'd0, 16'hAAAA, 1'b0);
    step("R9", 4'd6, 4'd4, 16'h5555, 1'b0);
    step("R9", 4'd6, 4'd0, 16'h1357, 1'b0);
    step("R9", 4'd6, 4'd15, 16'h9BDF, 1'b0);
    step("R9", 4'd6, 4'd8, 16'h00FF, 1'b1);
    step("R2", 4'd7, 4'd2, 16'h6C6C, 1'b0);

    repeat (3) @(posedge clk);
    #3;
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule